// File: doc/BRIEF.md
# CAN Controller Host Register and Interrupt Core

This block is the byte-wide host register file of a CAN controller that runs with its extended register map. A host reads and writes eight-bit registers through a five-bit address. The block holds mode, status, interrupt flags, interrupt enables and the clock divider. It sends single-cycle strobes to a transmit engine and to a receive buffer, and it drives one level-sensitive interrupt line. It also tracks whether the controller sits in reset mode or in operating mode. Protocol timing, bit timing and the message storage itself sit outside the block.

The receive buffer reports to this core in three ways. A pulse marks a stored message, a pulse marks an overrun, and a count input gives the number of messages still held. A transmit command is treated as complete in the same cycle, so the status and interrupt bits for a finished transmission appear straight away. Register writes and the side effect of reading the interrupt register take effect at the clock edge that samples the strobe. The interrupt line follows one cycle later.

Top module: `can_host_regs`

## Requirements
- R1: After hardware reset the registers hold these values: mode 0x01 (address 0), status 0x3C (address 2), interrupt flags 0x00 (address 3), interrupt enable 0x00 (address 4) and clock divider 0x00 (address 31). The `irq` output is low.
- R2: The clock divider at address 31 can always be read and written. While its bit 7 is 0, every other address reads 0xFF and writes to every other address have no effect.
- R3: A mode write stores only bits 4:0, so bits 7:5 read back as 0. Mode bit 0 drives `reset_mode` and mode bit 3 drives `single_filter`.
- R4: The command register (address 1) reads as 0x00. Writing it with bit 0 set pulses `tx_go` for one cycle, sets status bits 2 and 3, clears status bit 5 and sets interrupt bit 1.
- R5: A write to address 16 in operating mode (mode bit 0 = 0) sets status bit 5. The same write in reset mode leaves status unchanged.
- R6: A `rx_stored` pulse sets status bit 0 and interrupt bit 0. A `rx_overrun` pulse sets status bit 1 and interrupt bit 3.
- R7: A command write with bit 2 set pulses `rx_release` only when `rx_count` is non-zero. When `rx_count` is 1 it also clears status bit 0 and interrupt bit 0. When `rx_count` is 0 it has no effect.
- R8: A command write with bit 3 set clears status bit 1 and interrupt bit 3.
- R9: `irq` is high exactly one cycle after the bitwise AND of the interrupt-enable and interrupt registers is non-zero.
- R10: A read of address 3 returns the interrupt flags and clears them. Interrupt bit 0 is then set again at once if `rx_count` is non-zero.
- R11: A mode write that moves bit 0 from 0 to 1 sets status to (status AND NOT 0x37) OR 0x34 and pulses `rx_flush`. A mode write that moves bit 0 from 1 to 0 also pulses `rx_flush`.
- R12: Addresses 5 to 15 read 0x00 and addresses 16 to 30 read 0xFF. Writes to the status and interrupt registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_addr | input | ADDR_W | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (needed for the side effect of reading address 3) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current address |
| rx_stored | input | 1 | Receive buffer accepted a message |
| rx_overrun | input | 1 | Receive buffer dropped a message |
| rx_count | input | CNT_W | Messages held in the receive buffer |
| tx_go | output | 1 | Transmit request strobe |
| rx_release | output | 1 | Release-oldest-message strobe |
| rx_flush | output | 1 | Empty-receive-buffer strobe |
| reset_mode | output | 1 | Controller is in reset mode |
| single_filter | output | 1 | Single acceptance filter selected |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the host never raises `host_wr` and `host_rd` in the same cycle, and that `rx_count` changes only between commands, as it would after the receive buffer acts on a strobe. The stimulus performs one host access at a time. It changes `rx_count` only while the host bus is idle, and it pulses `rx_stored` and `rx_overrun` only in cycles without a host access.

// File: rtl/can_regs_pkg.sv
package can_regs_pkg;

    localparam int A_MODE  = 0;
    localparam int A_CMD   = 1;
    localparam int A_STAT  = 2;
    localparam int A_INTR  = 3;
    localparam int A_IEN   = 4;
    localparam int A_ZLO   = 5;
    localparam int A_ZHI   = 15;
    localparam int A_TXS   = 16;
    localparam int A_CDIV  = 31;

    localparam logic [7:0] STAT_RESET = 8'h3C;
    localparam logic [7:0] MODE_RESET = 8'h01;
    localparam logic [7:0] MODE_KEEP  = 8'h1F;
    localparam logic [7:0] SWR_CLEAR  = 8'h37;
    localparam logic [7:0] SWR_SET    = 8'h34;

    localparam int ST_RXFULL = 0;
    localparam int ST_OVR    = 1;
    localparam int ST_TXFREE = 2;
    localparam int ST_TXDONE = 3;
    localparam int ST_TXBUSY = 5;

    localparam int IF_RX  = 0;
    localparam int IF_TX  = 1;
    localparam int IF_OVR = 3;

    localparam int CMD_TX   = 0;
    localparam int CMD_REL  = 2;
    localparam int CMD_CLRO = 3;

    typedef struct packed {
        logic wr_mode;
        logic wr_cmd;
        logic wr_ien;
        logic wr_txs;
        logic wr_cdiv;
        logic rd_intr;
    } host_op_t;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] status;
        logic [7:0] intr;
        logic [7:0] ien;
        logic [7:0] cdiv;
        logic       tx_go;
        logic       rx_release;
        logic       rx_flush;
    } reg_state_t;

endpackage

// File: rtl/can_addr_decode.sv
module can_addr_decode
    import can_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              enhanced,
    output host_op_t          op
);
    localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
    localparam logic [ADDR_W-1:0] AD_CMD  = ADDR_W'(A_CMD);
    localparam logic [ADDR_W-1:0] AD_INTR = ADDR_W'(A_INTR);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_TXS  = ADDR_W'(A_TXS);
    localparam logic [ADDR_W-1:0] AD_CDIV = ADDR_W'(A_CDIV);

    logic wr_en;
    logic rd_en;

    always_comb begin
        wr_en      = host_wr && enhanced;
        rd_en      = host_rd && enhanced;
        op         = '0;
        op.wr_mode = wr_en && (host_addr == AD_MODE);
        op.wr_cmd  = wr_en && (host_addr == AD_CMD);
        op.wr_ien  = wr_en && (host_addr == AD_IEN);
        op.wr_txs  = wr_en && (host_addr == AD_TXS);
        op.wr_cdiv = host_wr && (host_addr == AD_CDIV);
        op.rd_intr = rd_en && (host_addr == AD_INTR);
    end

endmodule

// File: rtl/can_reg_core.sv
module can_reg_core
    import can_regs_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  host_op_t         op,
    input  logic [7:0]       wdata,
    input  logic             rx_stored,
    input  logic             rx_overrun,
    input  logic [CNT_W-1:0] rx_count,
    output reg_state_t       st
);
    localparam logic [CNT_W-1:0] ONE_MSG = CNT_W'(1);

    reg_state_t st_d, st_q;
    logic       nonempty;
    logic       last_msg;
    logic [7:0] ev_flags;

    always_comb begin
        st_d            = st_q;
        st_d.tx_go      = 1'b0;
        st_d.rx_release = 1'b0;
        st_d.rx_flush   = 1'b0;
        nonempty        = (rx_count != '0);
        last_msg        = (rx_count == ONE_MSG);

        ev_flags         = '0;
        ev_flags[IF_RX]  = rx_stored;
        ev_flags[IF_OVR] = rx_overrun;

        if (rx_stored)  st_d.status[ST_RXFULL] = 1'b1;
        if (rx_overrun) st_d.status[ST_OVR]    = 1'b1;

        if (op.rd_intr) st_d.intr = {7'b0, nonempty} | ev_flags;
        else            st_d.intr = st_q.intr | ev_flags;

        if (op.wr_mode) begin
            st_d.mode = wdata & MODE_KEEP;
            if (!st_q.mode[0] && wdata[0]) begin
                st_d.status   = (st_d.status & ~SWR_CLEAR) | SWR_SET;
                st_d.rx_flush = 1'b1;
            end
            if (st_q.mode[0] && !wdata[0]) st_d.rx_flush = 1'b1;
        end

        if (op.wr_cmd) begin
            if (wdata[CMD_TX]) begin
                st_d.tx_go             = 1'b1;
                st_d.status[ST_TXFREE] = 1'b1;
                st_d.status[ST_TXDONE] = 1'b1;
                st_d.status[ST_TXBUSY] = 1'b0;
                st_d.intr[IF_TX]       = 1'b1;
            end
            if (wdata[CMD_REL] && nonempty) begin
                st_d.rx_release = 1'b1;
                if (last_msg) begin
                    st_d.status[ST_RXFULL] = 1'b0;
                    st_d.intr[IF_RX]       = 1'b0;
                end
            end
            if (wdata[CMD_CLRO]) begin
                st_d.status[ST_OVR] = 1'b0;
                st_d.intr[IF_OVR]   = 1'b0;
            end
        end

        if (op.wr_ien)  st_d.ien  = wdata;
        if (op.wr_cdiv) st_d.cdiv = wdata;
        if (op.wr_txs && !st_q.mode[0]) st_d.status[ST_TXBUSY] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mode   <= MODE_RESET;
            st_q.status <= STAT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/can_read_mux.sv
module can_read_mux
    import can_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  reg_state_t        st,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
    localparam logic [ADDR_W-1:0] AD_CMD  = ADDR_W'(A_CMD);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_INTR = ADDR_W'(A_INTR);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_ZLO  = ADDR_W'(A_ZLO);
    localparam logic [ADDR_W-1:0] AD_ZHI  = ADDR_W'(A_ZHI);
    localparam logic [ADDR_W-1:0] AD_CDIV = ADDR_W'(A_CDIV);

    always_comb begin
        rdata = 8'hFF;
        if (host_addr == AD_CDIV)          rdata = st.cdiv;
        else if (!st.cdiv[7])              rdata = 8'hFF;
        else if (host_addr == AD_MODE)     rdata = st.mode;
        else if (host_addr == AD_CMD)      rdata = 8'h00;
        else if (host_addr == AD_STAT)     rdata = st.status;
        else if (host_addr == AD_INTR)     rdata = st.intr;
        else if (host_addr == AD_IEN)      rdata = st.ien;
        else if (host_addr >= AD_ZLO && host_addr <= AD_ZHI) rdata = 8'h00;
    end

endmodule

// File: rtl/can_irq_gen.sv
module can_irq_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] enables,
    input  logic [W-1:0] flags,
    output logic         irq
);
    logic [W-1:0] hit;
    logic         irq_d, irq_q;

    for (genvar i = 0; i < W; i++) begin : g_hit
        assign hit[i] = enables[i] & flags[i];
    end

    always_comb irq_d = |hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

endmodule

// File: rtl/can_host_regs.sv
module can_host_regs
    import can_regs_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              rx_stored,
    input  logic              rx_overrun,
    input  logic [CNT_W-1:0]  rx_count,
    output logic              tx_go,
    output logic              rx_release,
    output logic              rx_flush,
    output logic              reset_mode,
    output logic              single_filter,
    output logic              irq
);
    host_op_t   op;
    reg_state_t st;
    logic [7:0] mode_w, status_w, intr_w, ien_w;

    can_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .enhanced  (st.cdiv[7]),
        .op        (op)
    );

    can_reg_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .wdata      (host_wdata),
        .rx_stored  (rx_stored),
        .rx_overrun (rx_overrun),
        .rx_count   (rx_count),
        .st         (st)
    );

    can_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
        .host_addr (host_addr),
        .st        (st),
        .rdata     (host_rdata)
    );

    can_irq_gen #(.W(8)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .enables (st.ien),
        .flags   (st.intr),
        .irq     (irq)
    );

    assign mode_w        = st.mode;
    assign status_w      = st.status;
    assign intr_w        = st.intr;
    assign ien_w         = st.ien;
    assign tx_go         = st.tx_go;
    assign rx_release    = st.rx_release;
    assign rx_flush      = st.rx_flush;
    assign reset_mode    = st.mode[0];
    assign single_filter = st.mode[3];

endmodule

// File: rtl/can_host_regs_chk.sv
module can_host_regs_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       mode_w,
    input logic [7:0]       status_w,
    input logic [7:0]       intr_w,
    input logic [7:0]       ien_w,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_go,
    input logic             rx_release,
    input logic             rx_flush,
    input logic             reset_mode,
    input logic             irq
);
    AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mode_w[7:5] == 3'b000); // R3

    AST_TX_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> (status_w[3:2] == 2'b11 && !status_w[5] && intr_w[1])); // R4

    AST_RELEASE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_release |-> ($past(rx_count) != '0)); // R7

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(ien_w & intr_w))); // R9

    AST_SWRESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && reset_mode) |-> ((status_w & 8'h37) == 8'h34)); // R11

endmodule

bind can_host_regs can_host_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_w     (mode_w),
    .status_w   (status_w),
    .intr_w     (intr_w),
    .ien_w      (ien_w),
    .rx_count   (rx_count),
    .tx_go      (tx_go),
    .rx_release (rx_release),
    .rx_flush   (rx_flush),
    .reset_mode (reset_mode),
    .irq        (irq)
);

// File: tb/sim_can_host_regs.sv
module sim_can_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_stored = 1'b0;
    logic       rx_overrun = 1'b0;
    logic [5:0] rx_count = '0;
    logic       tx_go, rx_release, rx_flush, reset_mode, single_filter, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } item_t;
    item_t sb[$];
    event  chk_ev;

    always #10 clk = ~clk;

    can_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_stored(rx_stored), .rx_overrun(rx_overrun), .rx_count(rx_count),
        .tx_go(tx_go), .rx_release(rx_release), .rx_flush(rx_flush),
        .reset_mode(reset_mode), .single_filter(single_filter), .irq(irq)
    );

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return host_rdata;
            1: return {7'b0, irq};
            2: return {7'b0, tx_go};
            3: return {7'b0, rx_release};
            4: return {7'b0, rx_flush};
            5: return {7'b0, reset_mode};
            default: return {7'b0, single_filter};
        endcase
    endfunction

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_sig(int sel, logic [7:0] exp, string tag);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb.push_back(it);
        -> chk_ev;
        #2;
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        expect_sig(0, exp, tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic pulse_stored();
        @(negedge clk); rx_stored = 1'b1;
        @(negedge clk); rx_stored = 1'b0;
    endtask

    task automatic pulse_overrun();
        @(negedge clk); rx_overrun = 1'b1;
        @(negedge clk); rx_overrun = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_sig(1, 8'h00, "R1 irq low after reset");
        expect_sig(5, 8'h01, "R1 reset_mode after reset");
        expect_sig(2, 8'h00, "R1 tx_go idle");
        rd(5'd31, 8'h00, "R1 clock divider reset");
        rd(5'd0, 8'hFF, "R2 mode hidden in compact map");
        wr(5'd0, 8'h00);
        wr(5'd31, 8'h80);
        rd(5'd31, 8'h80, "R2 clock divider write");
        rd(5'd0, 8'h01, "R1 R2 mode reset value, hidden write ignored");
        rd(5'd2, 8'h3C, "R1 status reset");
        rd(5'd3, 8'h00, "R1 interrupt reset");
        rd(5'd4, 8'h00, "R1 enable reset");
        rd(5'd1, 8'h00, "R4 command reads zero");

        // R3 mode masking and mode outputs
        wr(5'd0, 8'hFF);
        rd(5'd0, 8'h1F, "R3 mode masked");
        expect_sig(6, 8'h01, "R3 single_filter");
        wr(5'd0, 8'h08);
        expect_sig(4, 8'h01, "R11 flush on leaving reset");
        expect_sig(5, 8'h00, "R3 operating mode");
        rd(5'd0, 8'h08, "R3 mode readback");

        // R4 transmit
        wr(5'd4, 8'h02);
        wr(5'd1, 8'h01);
        expect_sig(2, 8'h01, "R4 tx_go pulse");
        rd(5'd2, 8'h1C, "R4 status after transmit");
        idle();
        expect_sig(1, 8'h01, "R9 irq on transmit flag");
        rd(5'd3, 8'h02, "R10 interrupt read");
        idle();
        expect_sig(1, 8'h00, "R9 R10 irq after clear");
        rd(5'd3, 8'h00, "R10 cleared by read");

        // R5 address 16 in operating mode
        wr(5'd16, 8'h55);
        rd(5'd2, 8'h3C, "R5 transmitting bit set");

        // R6 receive
        rx_count = 6'd2;
        pulse_stored();
        rd(5'd2, 8'h3D, "R6 receive status");
        idle();
        expect_sig(1, 8'h00, "R9 masked receive flag");
        wr(5'd4, 8'h01);
        idle();
        expect_sig(1, 8'h01, "R9 enabled receive flag");
        rd(5'd3, 8'h01, "R10 read receive flag");
        rd(5'd3, 8'h01, "R10 receive flag re-set");
        idle();
        expect_sig(1, 8'h01, "R10 irq kept while pending");

        // R7 release
        wr(5'd1, 8'h04);
        expect_sig(3, 8'h01, "R7 release with two");
        rd(5'd2, 8'h3D, "R7 status kept with two");
        rx_count = 6'd1;
        wr(5'd1, 8'h04);
        expect_sig(3, 8'h01, "R7 release last");
        rx_count = 6'd0;
        rd(5'd2, 8'h3C, "R7 status cleared on last");
        rd(5'd3, 8'h00, "R7 interrupt cleared on last");
        idle();
        expect_sig(1, 8'h00, "R7 irq low when empty");
        wr(5'd1, 8'h04);
        expect_sig(3, 8'h00, "R7 no release when empty");
        rd(5'd2, 8'h3C, "R7 status unchanged when empty");

        // R6 R8 overrun
        wr(5'd4, 8'h08);
        pulse_overrun();
        rd(5'd2, 8'h3E, "R6 overrun status");
        idle();
        expect_sig(1, 8'h01, "R9 irq on overrun");
        wr(5'd1, 8'h08);
        rd(5'd2, 8'h3C, "R8 overrun status cleared");
        idle();
        expect_sig(1, 8'h00, "R8 irq after clear");
        rd(5'd3, 8'h00, "R8 overrun flag cleared");

        // R11 software reset
        wr(5'd1, 8'h01);
        rx_count = 6'd1;
        pulse_stored();
        pulse_overrun();
        rx_count = 6'd0;
        rd(5'd2, 8'h1F, "R6 status before reset");
        wr(5'd0, 8'h01);
        expect_sig(4, 8'h01, "R11 flush on entering reset");
        expect_sig(5, 8'h01, "R11 reset_mode");
        rd(5'd2, 8'h3C, "R11 software reset status");
        rd(5'd0, 8'h01, "R11 mode after software reset");

        // R5 R12 ignored writes in reset mode
        wr(5'd1, 8'h01);
        wr(5'd16, 8'hAA);
        rd(5'd2, 8'h1C, "R5 address 16 ignored in reset mode");
        wr(5'd2, 8'h00);
        rd(5'd2, 8'h1C, "R12 status write ignored");
        wr(5'd3, 8'h00);
        rd(5'd3, 8'h0B, "R12 interrupt write ignored");
        rd(5'd5, 8'h00, "R12 address 5");
        rd(5'd15, 8'h00, "R12 address 15");
        rd(5'd20, 8'hFF, "R12 address 20");
        rd(5'd30, 8'hFF, "R12 address 30");

        // R2 writes ignored in compact map
        wr(5'd31, 8'h00);
        wr(5'd4, 8'h33);
        rd(5'd4, 8'hFF, "R2 enable hidden");
        wr(5'd31, 8'h80);
        rd(5'd4, 8'h08, "R2 enable write ignored");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule